// File: doc/BRIEF.md
# Coverage-Tracking Stimulus Generator

This block drives a device under test with 4-bit input patterns, one pattern at a time, and keeps score of which of the 16 possible patterns have been applied so far. Each pattern leaves through a valid/ready stream port. Once a pattern is accepted, the block waits for a completion pulse from the external evaluator before it offers the next one. After every one of the 16 patterns has been applied at least once, the block raises a sticky flag and offers nothing more until the next reset.

The pattern source is chosen at reset. The counting source walks upward from zero and wraps at 16. The random source starts from zero and inverts exactly one bit per step. A 16-bit maximal-length shift register picks which bit to invert. The block reports four things: how many distinct patterns have been applied, that number as an integer percentage, how many applications hit a pattern already seen, and the all-covered flag.

The stream follows these back-pressure rules. `gen_valid_o` stays high and `gen_vec_o` stays unchanged until `gen_ready_i` is sampled high. `gen_apply_o` marks the single cycle in which the transfer happens. The stream never presents a new pattern without first receiving `eval_done_i`.

Top module: `stim_cov_gen`

## Requirements
- R1: After reset, `gen_valid_o` is 1, `gen_vec_o` is 0, and `cov_count_o`, `cov_pct_o`, `dup_count_o` and `all_cov_o` are all 0.
- R2: While `gen_valid_o` is 1 and `gen_ready_i` is 0, `gen_vec_o` holds its value. `gen_apply_o` equals `gen_valid_o & gen_ready_i` in the same cycle.
- R3: After a transfer, `gen_valid_o` drops on the next cycle and stays 0 until `eval_done_i` is sampled high. `eval_done_i` has no effect while `gen_valid_o` is 1. If coverage is not complete, the next pattern is valid in the cycle after `eval_done_i` was sampled.
- R4: In counting mode (`mode_i` = 0), successive patterns are 0, 1, 2, ... modulo 16.
- R5: In random mode (`mode_i` = 1), the first pattern is 0. Each later pattern equals the previous one XOR (1 << s[1:0]), where s is the shift-register state. The shift register is seeded with 0xACE1. It advances once for each new pattern, right after its low bits are used. One step is: take the low bit out, shift right by one, and XOR the result with 0xB400 if that low bit was 1.
- R6: Each accepted pattern is marked in a 16-entry seen-set. From the cycle after the transfer, `cov_count_o` shows the number of marked entries.
- R7: When an accepted pattern was already marked, `dup_count_o` increases by one from the cycle after the transfer. It saturates at its maximum value.
- R8: `cov_pct_o` always equals floor(`cov_count_o` * 100 / 16).
- R9: When the 16th distinct pattern is accepted, `all_cov_o` rises in the next cycle and stays 1. From then on `gen_valid_o` stays 0, whatever happens on `eval_done_i` or `gen_ready_i`.
- R10: `mode_i` is sampled only while `rst_n` is low. Changing it after reset does not alter the pattern sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 0 counting, 1 random single-bit toggle; sampled in reset |
| gen_valid_o | output | 1 | Pattern on `gen_vec_o` is offered |
| gen_ready_i | input | 1 | Downstream accepts the pattern |
| gen_vec_o | output | 4 | Test pattern |
| gen_apply_o | output | 1 | Transfer happens this cycle |
| eval_done_i | input | 1 | Evaluator finished with the last pattern |
| cov_count_o | output | 5 | Distinct patterns applied so far |
| cov_pct_o | output | 7 | Coverage in percent, truncated |
| dup_count_o | output | 16 | Applications of an already-seen pattern |
| all_cov_o | output | 1 | All 16 patterns seen; generation stopped |

## Verification
The embedded properties check several rules on every cycle:
- a stalled pattern stays stable;
- the distinct count never moves by more than one;
- the all-covered flag is sticky and blocks any further offer;
- successive random patterns differ in exactly one bit;
- successive counting patterns step by one.

Some behaviour only the bench's scenarios can show: the exact bit chosen by the shift register, the repeat tally and the percentage values as they evolve, the ignored completion pulse during an offer, and the insensitivity to `mode_i` after reset. The bench shows these by comparing every output against a behavioural model on every clock, with randomised ready and completion timing.

// File: rtl/stimgen_pkg.sv
package stimgen_pkg;
  typedef enum logic [1:0] {
    GEN_OFFER = 2'd0,
    GEN_AWAIT = 2'd1,
    GEN_HALT  = 2'd2
  } gen_state_e;

  localparam int unsigned PCT_FULL = 100;
endpackage

// File: rtl/stim_lfsr.sv
module stim_lfsr #(
  parameter int unsigned   LW   = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400,
  parameter logic [LW-1:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  output logic [LW-1:0] state_o
);
  logic [LW-1:0] st_q;
  logic [LW-1:0] st_d;

  always_comb begin
    st_d = {1'b0, st_q[LW-1:1]};
    if (st_q[0]) st_d = st_d ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      st_q <= SEED;
    else if (step_i) st_q <= st_d;
  end

  assign state_o = st_q;

  // R5
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
endmodule

// File: rtl/stim_next_vec.sv
module stim_next_vec #(
  parameter int unsigned VEC_W = 4,
  localparam int unsigned SEL_W = (VEC_W > 1) ? $clog2(VEC_W) : 1
) (
  input  logic             rand_mode_i,
  input  logic [VEC_W-1:0] cur_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [VEC_W-1:0] nxt_o
);
  logic [VEC_W-1:0] flip;

  for (genvar b = 0; b < VEC_W; b++) begin : g_flip
    assign flip[b] = (sel_i == SEL_W'(b));
  end

  assign nxt_o = rand_mode_i ? (cur_i ^ flip) : (cur_i + VEC_W'(1));
endmodule

// File: rtl/stim_cov_tracker.sv
module stim_cov_tracker #(
  parameter int unsigned VEC_W = 4,
  parameter int unsigned REP_W = 16,
  localparam int unsigned N_VEC = 1 << VEC_W,
  localparam int unsigned CNT_W = VEC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mark_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [CNT_W-1:0] count_o,
  output logic [REP_W-1:0] dup_o,
  output logic             all_o
);
  logic [N_VEC-1:0] seen_q, seen_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [REP_W-1:0] dup_q;
  logic             all_q;
  logic             hit;

  assign hit = seen_q[vec_i];

  always_comb begin
    seen_d = seen_q;
    if (mark_i) seen_d[vec_i] = 1'b1;
    cnt_d = '0;
    for (int i = 0; i < int'(N_VEC); i++) cnt_d = cnt_d + CNT_W'(seen_d[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= '0;
      cnt_q  <= '0;
      dup_q  <= '0;
      all_q  <= 1'b0;
    end else if (mark_i) begin
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
      if (hit && (dup_q != '1)) dup_q <= dup_q + REP_W'(1);
      if (cnt_d == CNT_W'(N_VEC)) all_q <= 1'b1;
    end
  end

  assign count_o = cnt_q;
  assign dup_o   = dup_q;
  assign all_o   = all_q;

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R9
  all_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_q |=> all_q);
  // R7
  dup_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dup_q >= $past(dup_q));
endmodule

// File: rtl/stim_cov_gen.sv
module stim_cov_gen #(
  parameter int unsigned VEC_W = 4,
  parameter int unsigned REP_W = 16,
  parameter int unsigned LW    = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400,
  parameter logic [LW-1:0] SEED = 16'hACE1,
  localparam int unsigned CNT_W = VEC_W + 1,
  localparam int unsigned PCT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  output logic             gen_valid_o,
  input  logic             gen_ready_i,
  output logic [VEC_W-1:0] gen_vec_o,
  output logic             gen_apply_o,
  input  logic             eval_done_i,
  output logic [CNT_W-1:0] cov_count_o,
  output logic [PCT_W-1:0] cov_pct_o,
  output logic [REP_W-1:0] dup_count_o,
  output logic             all_cov_o
);
  import stimgen_pkg::*;

  localparam int unsigned SEL_W = (VEC_W > 1) ? $clog2(VEC_W) : 1;
  localparam int unsigned MUL_W = CNT_W + PCT_W;

  gen_state_e       st_q;
  logic             rand_q;
  logic [VEC_W-1:0] vec_q, vec_nxt;
  logic [LW-1:0]    lfsr_s;
  logic             advance;
  logic             fire;
  logic [CNT_W-1:0] cnt;
  logic             all_cov;
  logic [MUL_W-1:0] pct_prod;

  always_ff @(posedge clk) begin
    if (!rst_n) rand_q <= mode_i;
  end

  assign fire    = (st_q == GEN_OFFER) && gen_ready_i;
  assign advance = (st_q == GEN_AWAIT) && eval_done_i && !all_cov;

  stim_lfsr #(.LW(LW), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (advance && rand_q),
    .state_o (lfsr_s)
  );

  stim_next_vec #(.VEC_W(VEC_W)) u_next (
    .rand_mode_i (rand_q),
    .cur_i       (vec_q),
    .sel_i       (lfsr_s[SEL_W-1:0]),
    .nxt_o       (vec_nxt)
  );

  stim_cov_tracker #(.VEC_W(VEC_W), .REP_W(REP_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .mark_i  (fire),
    .vec_i   (vec_q),
    .count_o (cnt),
    .dup_o   (dup_count_o),
    .all_o   (all_cov)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= GEN_OFFER;
      vec_q <= '0;
    end else begin
      unique case (st_q)
        GEN_OFFER: if (gen_ready_i) st_q <= GEN_AWAIT;
        GEN_AWAIT: if (eval_done_i) begin
          if (all_cov) st_q <= GEN_HALT;
          else begin
            st_q  <= GEN_OFFER;
            vec_q <= vec_nxt;
          end
        end
        default: st_q <= GEN_HALT;
      endcase
    end
  end

  assign pct_prod    = MUL_W'(cnt) * MUL_W'(PCT_FULL);
  assign cov_pct_o   = PCT_W'(pct_prod >> VEC_W);
  assign cov_count_o = cnt;
  assign all_cov_o   = all_cov;
  assign gen_valid_o = (st_q == GEN_OFFER);
  assign gen_vec_o   = vec_q;
  assign gen_apply_o = fire;

  // state for the step-shape properties below
  logic [VEC_W-1:0] last_vec_q;
  logic             have_last_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_vec_q  <= '0;
      have_last_q <= 1'b0;
    end else if (fire) begin
      last_vec_q  <= vec_q;
      have_last_q <= 1'b1;
    end
  end

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_valid_o && !gen_ready_i |=> gen_valid_o && $stable(gen_vec_o));
  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_cov_o |-> !gen_valid_o);
  // R5
  one_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_valid_o) && have_last_q && rand_q
      |-> $countones(gen_vec_o ^ last_vec_q) == 1);
  // R4
  count_step_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_valid_o) && have_last_q && !rand_q
      |-> gen_vec_o == last_vec_q + VEC_W'(1));
  // R3
  await_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_apply_o |=> !gen_valid_o);
endmodule

// File: tb/tb_stim_cov_gen.sv
module tb_stim_cov_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i = 1'b0;
  logic gen_ready_i = 1'b0;
  logic eval_done_i = 1'b0;
  logic gen_valid_o, gen_apply_o, all_cov_o;
  logic [3:0]  gen_vec_o;
  logic [4:0]  cov_count_o;
  logic [6:0]  cov_pct_o;
  logic [15:0] dup_count_o;

  always #2 clk = ~clk;

  stim_cov_gen dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .gen_valid_o(gen_valid_o), .gen_ready_i(gen_ready_i),
    .gen_vec_o(gen_vec_o), .gen_apply_o(gen_apply_o),
    .eval_done_i(eval_done_i), .cov_count_o(cov_count_o),
    .cov_pct_o(cov_pct_o), .dup_count_o(dup_count_o),
    .all_cov_o(all_cov_o)
  );

  int checks = 0;
  int errors = 0;

  // behavioural model: 0 offering, 1 awaiting, 2 halted
  int m_phase, m_vec, m_lfsr, m_cnt, m_dup;
  bit m_rand, m_all;
  bit m_seen[16];

  function automatic int lfsr_step(int s);
    int r;
    r = s >> 1;
    if (s & 1) r = r ^ 'hB400;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rand = mode_i; m_phase = 0; m_vec = 0; m_lfsr = 'hACE1;
      m_cnt = 0; m_dup = 0; m_all = 0;
      foreach (m_seen[i]) m_seen[i] = 0;
    end else if (m_phase == 0) begin
      if (gen_ready_i) begin
        if (m_seen[m_vec]) begin
          if (m_dup < 65535) m_dup++;
        end else begin
          m_seen[m_vec] = 1; m_cnt++;
          if (m_cnt == 16) m_all = 1;
        end
        m_phase = 1;
      end
    end else if (m_phase == 1) begin
      if (eval_done_i) begin
        if (m_all) m_phase = 2;
        else begin
          if (m_rand) begin
            m_vec = m_vec ^ (1 << (m_lfsr & 3));
            m_lfsr = lfsr_step(m_lfsr);
          end else m_vec = (m_vec + 1) % 16;
          m_phase = 0;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 valid", gen_valid_o, m_phase == 0);
    chk("R2 apply", gen_apply_o, (m_phase == 0) && gen_ready_i);
    if (m_phase == 0) chk(m_rand ? "R5 R10 vector" : "R4 vector", gen_vec_o, m_vec);
    chk("R6 count", cov_count_o, m_cnt);
    chk("R8 pct", cov_pct_o, (m_cnt * 100) / 16);
    chk("R7 dups", dup_count_o, m_dup);
    chk("R9 all", all_cov_o, m_all);
  endtask

  task automatic run_phase(bit md, bit flip_mode);
    int tail = 0;
    mode_i = md; rst_n = 0; gen_ready_i = 0; eval_done_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", gen_valid_o, 1);
    chk("R1 vec", gen_vec_o, 0);
    chk("R1 count", cov_count_o, 0);
    chk("R1 pct", cov_pct_o, 0);
    chk("R1 dups", dup_count_o, 0);
    chk("R1 all", all_cov_o, 0);
    if (flip_mode) mode_i = ~md;   // R10: no effect after reset
    for (int cyc = 0; cyc < 60000; cyc++) begin
      compare_all();
      if (m_all) tail++;
      if (tail > 40) break;
      gen_ready_i = ($urandom_range(0, 9) < 6);
      eval_done_i = (m_all && tail > 5) ? 1'b1 : ($urandom_range(0, 9) < 4);
      if (tail > 20) gen_ready_i = 1'b1;  // R9: stimulus cannot restart it
      @(negedge clk);
    end
    chk("R9 reached", all_cov_o, 1);
    chk("R6 final count", cov_count_o, 16);
    chk("R8 final pct", cov_pct_o, 100);
    if (!md) chk("R7 counting no repeats", dup_count_o, 0);
  endtask

  initial begin
    fork
      begin
        run_phase(1'b0, 1'b0);
        run_phase(1'b1, 1'b1);
        run_phase(1'b0, 1'b1);
      end
      begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule